// File: doc/BRIEF.md
# Packed Single-Precision Maximum Unit

This block takes two packed vectors of IEEE-754 single-precision numbers and returns, for each 32-bit lane, the larger of the pair. Its selection rule is deliberately lopsided. Whenever the two values are both zeros, or either one is a NaN, the lane from the second operand (`src_b_i`) is returned as it is. A signalling NaN in that operand therefore comes out unchanged, without being quieted.

Around the per-lane compare sit the vector controls. The active length can be 4, 8 or 16 lanes, and everything above it is cleared. A per-lane write mask decides which lanes take the maximum. Lanes that are masked off either keep the old destination contents or are cleared. A broadcast option compares lane 0 of the second operand against every lane of the first. Two sticky flags record NaN inputs and subnormal inputs seen in active lanes.

Operands are taken when `valid_i` is high. The result appears, registered, one cycle later together with `valid_o`. The result then holds until the next accepted operation.

Top module: `vmax_unit`

## Requirements
- R1: Each active lane picks its result in this priority order. If both inputs are zeros of either sign, the output is the second operand. Otherwise, if the first input is NaN, the output is the second operand. Otherwise, if the second input is NaN, the output is the second operand. Otherwise the output is the first operand when it is strictly greater, and the second operand if not.
- R2: A signalling NaN taken from the second operand (for example 0x7F800001) appears at the output bit-for-bit unchanged.
- R3: The greater-than test uses sign-magnitude ordering. Between two negative values, the one with the smaller magnitude is greater. Infinities (exponent 0xFF, fraction 0) are ordered like any other value.
- R4: `vlen_i` selects the active length: 2'b00 gives 4 lanes (bits 127:0), 2'b01 gives 8 lanes (bits 255:0), and 2'b10 or 2'b11 gives 16 lanes. Every result bit above the active length is zero.
- R5: An in-length lane receives the maximum when `mask_en_i` is low, or when its bit in `mask_i` is set. Lane j is controlled by `mask_i[j]`, and lane j occupies bits 32j+31:32j.
- R6: For an in-length lane whose mask bit is clear while `mask_en_i` is high, the output depends on `zero_mode_i`. When it is low, the lane takes the matching lane of `old_dst_i`. When it is high, the lane is written with zero.
- R7: When `bcast_i` is high, bits 31:0 of `src_b_i` act as the second operand for every lane. The other bits of `src_b_i` have no effect.
- R8: `invalid_o` is set when an accepted operation has a NaN (exponent all ones, fraction non-zero) in either input of any active lane. It then stays set until reset.
- R9: `denormal_o` is set when an accepted operation has a subnormal (exponent zero, fraction non-zero) in either input of any active lane. It then stays set until reset.
- R10: Lanes that are masked off, and lanes beyond the active length, never set either flag.
- R11: Reset clears `result_o`, `valid_o` and both flags. An operation accepted on `valid_i` produces `valid_o` and its result one cycle later. The result then holds while `valid_i` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Accept operands this cycle |
| src_a_i | input | 512 | First operand vector |
| src_b_i | input | 512 | Second operand vector |
| old_dst_i | input | 512 | Previous destination contents, used for merging |
| mask_en_i | input | 1 | Enable per-lane masking |
| mask_i | input | 16 | Per-lane write mask |
| zero_mode_i | input | 1 | 1: clear masked lanes, 0: merge masked lanes |
| bcast_i | input | 1 | Use lane 0 of src_b_i for all lanes |
| vlen_i | input | 2 | Active vector length select |
| valid_o | output | 1 | Result valid |
| result_o | output | 512 | Registered result vector |
| invalid_o | output | 1 | Sticky NaN-input flag |
| denormal_o | output | 1 | Sticky subnormal-input flag |

## Verification
The assertions assume that every control input (`vlen_i`, `mask_en_i`, `mask_i`, `zero_mode_i`, `bcast_i`) and every operand is a known value whenever `valid_i` is high. Nothing is assumed about these inputs in cycles where `valid_i` is low. The bench drives every field with defined values on the falling edge before each accepted operation. It returns `valid_i` to low afterwards, and it changes operands only in idle cycles when it is checking the hold behaviour. Flag tests begin with a fresh reset, because the flags are sticky and only reset can show their cleared state.

// File: rtl/vmax_pkg.sv
package vmax_pkg;
  localparam int unsigned EW     = 32;
  localparam int unsigned EXP_W  = 8;
  localparam int unsigned FRAC_W = 23;

  typedef struct packed {
    logic              sign;
    logic [EXP_W-1:0]  exp;
    logic [FRAC_W-1:0] frac;
  } sp_t;

  typedef enum logic [1:0] {
    VL_4  = 2'b00,
    VL_8  = 2'b01,
    VL_16 = 2'b10,
    VL_16B = 2'b11
  } vlen_e;

  function automatic logic sp_is_nan(input sp_t v);
    return (&v.exp) && (|v.frac);
  endfunction

  function automatic logic sp_is_den(input sp_t v);
    return (~|v.exp) && (|v.frac);
  endfunction

  function automatic logic sp_is_zero(input sp_t v);
    return (~|v.exp) && (~|v.frac);
  endfunction
endpackage

// File: rtl/vmax_lane.sv
module vmax_lane
  import vmax_pkg::*;
(
  input  sp_t  a_i,
  input  sp_t  b_i,
  output sp_t  max_o,
  output logic nan_o,
  output logic den_o
);
  logic a_nan, b_nan, both_zero, a_gt_b;
  logic [EW-2:0] a_mag, b_mag;

  assign a_nan     = sp_is_nan(a_i);
  assign b_nan     = sp_is_nan(b_i);
  assign both_zero = sp_is_zero(a_i) && sp_is_zero(b_i);
  assign a_mag     = {a_i.exp, a_i.frac};
  assign b_mag     = {b_i.exp, b_i.frac};

  // sign-magnitude ordering, infinities included
  always_comb begin
    unique case ({a_i.sign, b_i.sign})
      2'b01:   a_gt_b = 1'b1;
      2'b10:   a_gt_b = 1'b0;
      2'b00:   a_gt_b = a_mag > b_mag;
      default: a_gt_b = a_mag < b_mag;
    endcase
  end

  always_comb begin
    if (both_zero || a_nan || b_nan) max_o = b_i;
    else if (a_gt_b)                 max_o = a_i;
    else                             max_o = b_i;
  end

  assign nan_o = a_nan || b_nan;
  assign den_o = sp_is_den(a_i) || sp_is_den(b_i);
endmodule

// File: rtl/vmax_lane_en.sv
module vmax_lane_en
  import vmax_pkg::*;
#(
  parameter int unsigned LANES = 16
) (
  input  logic [1:0]       vlen_i,
  input  logic             mask_en_i,
  input  logic [LANES-1:0] mask_i,
  output logic [LANES-1:0] in_len_o,
  output logic [LANES-1:0] wr_o
);
  localparam int unsigned CNT_W = $clog2(LANES + 1);
  logic [CNT_W-1:0] n_act;

  always_comb begin
    unique case (vlen_e'(vlen_i))
      VL_4:    n_act = CNT_W'(4);
      VL_8:    n_act = CNT_W'(8);
      default: n_act = CNT_W'(16);
    endcase
  end

  for (genvar j = 0; j < LANES; j++) begin : g_en
    assign in_len_o[j] = CNT_W'(j) < n_act;
    assign wr_o[j]     = in_len_o[j] && (!mask_en_i || mask_i[j]);
  end
endmodule

// File: rtl/vmax_flag_acc.sv
module vmax_flag_acc (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic upd_i,
  input  logic inv_i,
  input  logic den_i,
  output logic inv_o,
  output logic den_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inv_o <= 1'b0;
      den_o <= 1'b0;
    end else if (upd_i) begin
      inv_o <= inv_o | inv_i;
      den_o <= den_o | den_i;
    end
  end

  AST_INV_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_o |=> inv_o); // R8
  AST_DEN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    den_o |=> den_o); // R9
endmodule

// File: rtl/vmax_unit.sv
module vmax_unit
  import vmax_pkg::*;
#(
  parameter int unsigned LANES = 16,
  localparam int unsigned VW   = LANES * EW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [VW-1:0]    src_a_i,
  input  logic [VW-1:0]    src_b_i,
  input  logic [VW-1:0]    old_dst_i,
  input  logic             mask_en_i,
  input  logic [LANES-1:0] mask_i,
  input  logic             zero_mode_i,
  input  logic             bcast_i,
  input  logic [1:0]       vlen_i,
  output logic             valid_o,
  output logic [VW-1:0]    result_o,
  output logic             invalid_o,
  output logic             denormal_o
);
  logic [LANES-1:0] in_len, wr, lane_nan, lane_den;
  logic [VW-1:0]    b_eff, lane_max, res_d;

  vmax_lane_en #(.LANES(LANES)) u_en (
    .vlen_i   (vlen_i),
    .mask_en_i(mask_en_i),
    .mask_i   (mask_i),
    .in_len_o (in_len),
    .wr_o     (wr)
  );

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    sp_t mx;
    assign b_eff[j*EW +: EW] = bcast_i ? src_b_i[EW-1:0] : src_b_i[j*EW +: EW];

    vmax_lane u_lane (
      .a_i  (sp_t'(src_a_i[j*EW +: EW])),
      .b_i  (sp_t'(b_eff[j*EW +: EW])),
      .max_o(mx),
      .nan_o(lane_nan[j]),
      .den_o(lane_den[j])
    );
    assign lane_max[j*EW +: EW] = mx;

    always_comb begin
      if (!in_len[j])      res_d[j*EW +: EW] = '0;
      else if (wr[j])      res_d[j*EW +: EW] = lane_max[j*EW +: EW];
      else if (zero_mode_i) res_d[j*EW +: EW] = '0;
      else                 res_d[j*EW +: EW] = old_dst_i[j*EW +: EW];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) result_o <= res_d;
    end
  end

  vmax_flag_acc u_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .upd_i (valid_i),
    .inv_i (|(lane_nan & wr)),
    .den_i (|(lane_den & wr)),
    .inv_o (invalid_o),
    .den_o (denormal_o)
  );

  AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R11
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o)); // R11
  AST_UPPER_ZERO_4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && vlen_i == 2'b00) |=> (result_o[VW-1:4*EW] == '0)); // R4
  AST_UPPER_ZERO_8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && vlen_i == 2'b01) |=> (result_o[VW-1:8*EW] == '0)); // R4
  AST_ZERO_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mask_en_i && zero_mode_i && !mask_i[0]) |=> (result_o[EW-1:0] == '0)); // R6
  AST_MERGE_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mask_en_i && !zero_mode_i && !mask_i[0])
      |=> (result_o[EW-1:0] == $past(old_dst_i[EW-1:0]))); // R6
  AST_B_NAN_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && wr[0] && sp_is_nan(sp_t'(b_eff[EW-1:0])))
      |=> (result_o[EW-1:0] == $past(b_eff[EW-1:0]))); // R2
  AST_NO_FLAG_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && wr == '0 && !invalid_o) |=> !invalid_o); // R10
endmodule

// File: tb/vmax_unit_tb_top.sv
module vmax_unit_tb_top;
  localparam int L = 16;
  localparam int W = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid_i = 1'b0;
  logic [W-1:0] a = '0, b = '0, old = '0;
  logic mask_en = 1'b0, zmode = 1'b0, bcast = 1'b0;
  logic [L-1:0] mask = '0;
  logic [1:0] vlen = 2'b10;
  logic valid_o, inv_o, den_o;
  logic [W-1:0] res_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vmax_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i),
    .src_a_i(a), .src_b_i(b), .old_dst_i(old),
    .mask_en_i(mask_en), .mask_i(mask), .zero_mode_i(zmode),
    .bcast_i(bcast), .vlen_i(vlen),
    .valid_o(valid_o), .result_o(res_o),
    .invalid_o(inv_o), .denormal_o(den_o)
  );

  function automatic logic [W-1:0] rep(input logic [31:0] w, input int n);
    logic [W-1:0] v = '0;
    for (int j = 0; j < n; j++) v[j*32 +: 32] = w;
    return v;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Drive one operation and sample after the capturing edge
  task automatic run_op();
    valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic defaults();
    mask_en = 0; zmode = 0; bcast = 0; mask = '0; vlen = 2'b10;
    old = '0;
  endtask

  task automatic t_reset();
    chk("R11 reset result", res_o, '0);
    chk("R11 reset flags", {510'd0, inv_o, den_o}, '0);
    chk("R11 reset valid", {511'd0, valid_o}, '0);
  endtask

  task automatic t_basic();
    logic [W-1:0] e;
    defaults();
    a = rep(32'h3f800000, 16);
    for (int j = 0; j < 16; j++) b[j*32 +: 32] = (j % 2 == 0) ? 32'h40000000 : 32'h3f000000;
    for (int j = 0; j < 16; j++) e[j*32 +: 32] = (j % 2 == 0) ? 32'h40000000 : 32'h3f800000;
    valid_i = 1'b1;
    @(negedge clk);
    chk("R11 valid_o one cycle", {511'd0, valid_o}, 512'd1);
    valid_i = 1'b0;
    chk("R1 R5 basic max", res_o, e);
    @(negedge clk);
    chk("R11 valid_o drops", {511'd0, valid_o}, '0);
  endtask

  task automatic t_special();
    logic [W-1:0] e = '0;
    defaults();
    a = '0; b = '0;
    a[0*32 +: 32] = 32'h00000000; b[0*32 +: 32] = 32'h80000000; e[0*32 +: 32] = 32'h80000000;
    a[1*32 +: 32] = 32'h80000000; b[1*32 +: 32] = 32'h00000000; e[1*32 +: 32] = 32'h00000000;
    a[2*32 +: 32] = 32'h7fc00000; b[2*32 +: 32] = 32'h3f800000; e[2*32 +: 32] = 32'h3f800000;
    a[3*32 +: 32] = 32'h3f800000; b[3*32 +: 32] = 32'h7f800001; e[3*32 +: 32] = 32'h7f800001;
    a[4*32 +: 32] = 32'hbf800000; b[4*32 +: 32] = 32'hc0000000; e[4*32 +: 32] = 32'hbf800000;
    a[5*32 +: 32] = 32'h7f800000; b[5*32 +: 32] = 32'h3f800000; e[5*32 +: 32] = 32'h7f800000;
    a[6*32 +: 32] = 32'hff800000; b[6*32 +: 32] = 32'hbf800000; e[6*32 +: 32] = 32'hbf800000;
    a[7*32 +: 32] = 32'h40000000; b[7*32 +: 32] = 32'h40000000; e[7*32 +: 32] = 32'h40000000;
    a[8*32 +: 32] = 32'hc0400000; b[8*32 +: 32] = 32'h3f000000; e[8*32 +: 32] = 32'h3f000000;
    run_op();
    chk("R1 zeros favour second", res_o[63:0], e[63:0]);
    chk("R1 first NaN gives second", res_o[95:64], e[95:64]);
    chk("R2 sNaN passes unquieted", res_o[127:96], e[127:96]);
    chk("R3 negatives and infinities", res_o[223:128], e[223:128]);
    chk("R3 mixed sign and equal", res_o[W-1:224], e[W-1:224]);
  endtask

  task automatic t_vlen();
    defaults();
    a = rep(32'h40400000, 16); b = rep(32'h3f800000, 16);
    vlen = 2'b00; run_op();
    chk("R4 length 4", res_o, rep(32'h40400000, 4));
    vlen = 2'b01; run_op();
    chk("R4 length 8", res_o, rep(32'h40400000, 8));
    vlen = 2'b11; run_op();
    chk("R4 length 16 alt code", res_o, rep(32'h40400000, 16));
  endtask

  task automatic t_mask();
    logic [W-1:0] e;
    defaults();
    a = rep(32'h40400000, 16); b = rep(32'h3f800000, 16);
    old = rep(32'h12345678, 16);
    mask_en = 1; mask = 16'h00ff; zmode = 0;
    run_op();
    e = rep(32'h40400000, 8) | (rep(32'h12345678, 16) & ~rep(32'hffffffff, 8));
    chk("R6 merge keeps old lanes", res_o, e);
    zmode = 1; run_op();
    chk("R6 zero mode clears lanes", res_o, rep(32'h40400000, 8));
    mask = 16'hffff; zmode = 1; run_op();
    chk("R5 full mask writes all", res_o, rep(32'h40400000, 16));
  endtask

  task automatic t_bcast();
    defaults();
    a = rep(32'h3f800000, 16);
    b = rep(32'h42c80000, 16);
    b[31:0] = 32'h40a00000;
    bcast = 1; run_op();
    chk("R7 broadcast lane 0", res_o, rep(32'h40a00000, 16));
  endtask

  task automatic t_flags();
    do_reset();
    defaults();
    a = rep(32'h3f800000, 16); b = rep(32'h3f800000, 16);
    a[3*32 +: 32] = 32'h7fc00000;
    a[4*32 +: 32] = 32'h00000001;
    mask_en = 1; mask = 16'hffe7;
    run_op();
    chk("R10 masked lanes raise no flag", {510'd0, inv_o, den_o}, '0);
    defaults();
    a = rep(32'h3f800000, 16); b = rep(32'h3f800000, 16);
    b[5*32 +: 32] = 32'h7f800001;
    b[6*32 +: 32] = 32'h00400000;
    vlen = 2'b00; run_op();
    chk("R10 lanes beyond length raise no flag", {510'd0, inv_o, den_o}, '0);
    vlen = 2'b01; run_op();
    chk("R8 R9 active NaN and subnormal", {510'd0, inv_o, den_o}, 512'd3);
    a = rep(32'h3f800000, 16); b = rep(32'h3f800000, 16);
    run_op();
    chk("R8 R9 flags sticky", {510'd0, inv_o, den_o}, 512'd3);
    do_reset();
    chk("R11 reset clears flags", {510'd0, inv_o, den_o}, '0);
  endtask

  task automatic t_hold();
    logic [W-1:0] snap;
    defaults();
    a = rep(32'h40000000, 16); b = rep(32'h3f800000, 16);
    run_op();
    snap = res_o;
    a = rep(32'h41000000, 16);
    repeat (3) @(negedge clk);
    chk("R11 hold without valid", res_o, snap);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_basic();
    t_special();
    t_vlen();
    t_mask();
    t_bcast();
    t_hold();
    t_flags();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule